// File: doc/BRIEF.md
# Multi-Lane Serial Result Shifter

This block sends six 16-bit conversion results out over as many as three serial data lanes. The results are grouped as three channel pairs, A (A0, A1), B (B0, B1) and C (C0, C1). An external host supplies a serial clock and a frame sync. A frame opens on the falling edge of frame sync, with the serial clock idling high. From then on, every rising serial-clock edge moves each lane on by one bit. The host samples the lanes on the falling edges.

Two lane-select inputs decide how the pairs are spread over the lanes. Lane A is always in use. Pair C can take a lane of its own, or be folded behind pairs A and B. In the narrowest setting, lane A carries all six words by itself. With the chain enable set, each active lane shifts in bits from its own upstream input. Those bits leave the lane right after its local words, which lets several devices be chained onto the same lanes.

The block runs on one system clock. The serial clock, frame sync and chain inputs pass through a synchronizer before any edge is detected. Each level of serial clock and frame sync must therefore last at least four system-clock periods. An output settles within three system-clock cycles of the serial-clock edge that moved it.

Top module: `sershift_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame starts, all three lane outputs are 0.
- R2: A falling edge on frame sync, with the serial clock high, starts a frame. Each lane then presents bit 15 of its first word. Each later rising serial-clock edge while frame sync stays low advances every lane by exactly one bit, with words sent MSB first and back to back.
- R3: With select B = 1 and select C = 1, lane A carries A0 then A1, lane B carries B0 then B1, and lane C carries C0 then C1.
- R4: With select B = 1 and select C = 0, lane A carries A0, A1, C0 and lane B carries B0, B1, C1, in that order. Lane C outputs 0.
- R5: With select B = 0 and select C = 0, lane A carries A0, A1, B0, B1, C0, C1 in that order. Lanes B and C output 0.
- R6: With select B = 0 and select C = 1, lane A carries A0, A1, B0, B1 and lane C carries C0 then C1. Lane B outputs 0.
- R7: With chain enable = 1, each active lane follows its last local bit with the bits found on its own chain input. Those bits come out in the order they were present at the rising serial-clock edges, starting with the first rising edge of the frame.
- R8: With chain enable = 0, an active lane outputs 0 after its last local bit. An inactive lane outputs 0 for the whole frame even when chain enable = 1 and its chain input toggles.
- R9: While frame sync is high, serial-clock edges leave all three lane outputs unchanged.
- R10: The result words, the lane selects and chain enable are sampled only at the start of a frame. Changing them mid-frame does not alter that frame's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wordA0 | input | 16 | Result word of channel A0 |
| wordA1 | input | 16 | Result word of channel A1 |
| wordB0 | input | 16 | Result word of channel B0 |
| wordB1 | input | 16 | Result word of channel B1 |
| wordC0 | input | 16 | Result word of channel C0 |
| wordC1 | input | 16 | Result word of channel C1 |
| serClk | input | 1 | Serial clock from the host, idle high |
| frameSync | input | 1 | Frame sync; a falling edge starts a frame, high ends it |
| laneSelB | input | 1 | Lane B select |
| laneSelC | input | 1 | Lane C select |
| chainEn | input | 1 | Chain enable |
| chainInA | input | 1 | Upstream chain data for lane A |
| chainInB | input | 1 | Upstream chain data for lane B |
| chainInC | input | 1 | Upstream chain data for lane C |
| sdoA | output | 1 | Serial data, lane A |
| sdoB | output | 1 | Serial data, lane B |
| sdoC | output | 1 | Serial data, lane C |

## Verification
On every cycle, the assertions check three things. The outputs are quiet when reset is released. A lane whose select was latched low stays at 0. No output moves unless the control has issued a load or a shift strobe, which covers the hold while frame sync is high. Only the bench's scenarios can show the rest. That covers the word order on each lane in every select setting, the MSB-first bit order, the exact place where chain bits start, and the fact that inputs changed mid-frame are ignored. The bench compares whole captured bit streams against expected streams it builds from the requirements.

// File: rtl/sershift_pkg.sv
package sershift_pkg;

  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;

  typedef struct packed {
    logic selB;
    logic selC;
    logic dcen;
  } mode_t;

  localparam int NUM_LANES = 3;
  localparam int NUM_WORDS = 6;

  // Number of local words a lane carries for a given select setting
  function automatic int laneWords(input int lane, input logic selB, input logic selC);
    int n;
    case (lane)
      0: begin
        if (selB && selC) n = 2;
        else if (selB) n = 3;
        else if (selC) n = 4;
        else n = 6;
      end
      1: n = selB ? (selC ? 2 : 3) : 0;
      default: n = selC ? 2 : 0;
    endcase
    return n;
  endfunction

  // Width of a lane register, sized for its widest setting
  function automatic int laneLen(input int lane, input int wordW);
    return (lane == 0) ? 6 * wordW : ((lane == 1) ? 3 * wordW : 2 * wordW);
  endfunction

endpackage

// File: rtl/sershift_sync.sv
module sershift_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sershift_lane.sv
module sershift_lane #(
  parameter int LEN = 32,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [LEN-1:0]   loadVal,
  input  logic             din,
  input  logic [IDX_W-1:0] tap,
  output logic             sdo
);

  logic [LEN-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else if (load) sreg <= loadVal;
    else if (shift) sreg <= {sreg[LEN-2:0], din};
  end

  // The stream leaves from the tap that sits above the last loaded word
  assign sdo = sreg[tap];

endmodule

// File: rtl/sershift_ctrl.sv
module sershift_ctrl
  import sershift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serClk,
  input  logic                 frameSync,
  input  logic [NUM_LANES-1:0] chainIn,
  output strobe_t              strb,
  output logic [NUM_LANES-1:0] chainSync
);

  logic [1:0] edgeSync;
  logic       sclkS, fsS, sclkPrev, fsPrev;

  sershift_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) uSyncClk (
    .clk(clk), .rst(rst), .d({serClk, frameSync}), .q(edgeSync)
  );

  sershift_sync #(.W(NUM_LANES), .STAGES(SYNC_STAGES), .RST_VAL('0)) uSyncChain (
    .clk(clk), .rst(rst), .d(chainIn), .q(chainSync)
  );

  assign sclkS = edgeSync[1];
  assign fsS   = edgeSync[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPrev <= 1'b1;
      fsPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      fsPrev   <= fsS;
    end
  end

  always_comb begin
    strb.load  = fsPrev & ~fsS;
    strb.shift = sclkS & ~sclkPrev & ~fsS & ~fsPrev;
  end

endmodule

// File: rtl/sershift_dp.sv
module sershift_dp
  import sershift_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  strobe_t                          strb,
  input  mode_t                            modeIn,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  input  logic [NUM_LANES-1:0]             chainSync,
  output mode_t                            modeQ,
  output logic [NUM_LANES-1:0]             sdo
);

  localparam int LEN_MAX = laneLen(0, WORD_W);
  localparam int IDX_MAX = $clog2(LEN_MAX);

  logic [NUM_LANES-1:0][LEN_MAX-1:0] loadVal;
  logic [NUM_LANES-1:0][IDX_MAX-1:0] tap;
  logic [NUM_LANES-1:0]              din;

  always_ff @(posedge clk) begin
    if (rst) modeQ <= '0;
    else if (strb.load) modeQ <= modeIn;
  end

  // Right-aligned images: the first word sent sits highest
  always_comb begin
    loadVal = '0;
    case ({modeIn.selB, modeIn.selC})
      2'b11: begin
        loadVal[0] = LEN_MAX'({words[0], words[1]});
        loadVal[1] = LEN_MAX'({words[2], words[3]});
        loadVal[2] = LEN_MAX'({words[4], words[5]});
      end
      2'b10: begin
        loadVal[0] = LEN_MAX'({words[0], words[1], words[4]});
        loadVal[1] = LEN_MAX'({words[2], words[3], words[5]});
      end
      2'b01: begin
        loadVal[0] = LEN_MAX'({words[0], words[1], words[2], words[3]});
        loadVal[2] = LEN_MAX'({words[4], words[5]});
      end
      default: begin
        loadVal[0] = LEN_MAX'({words[0], words[1], words[2], words[3], words[4], words[5]});
      end
    endcase
  end

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      int n;
      n = laneWords(l, modeQ.selB, modeQ.selC);
      tap[l] = (n == 0) ? '0 : IDX_MAX'(n * WORD_W - 1);
    end
    din[0] = chainSync[0] & modeQ.dcen;
    din[1] = chainSync[1] & modeQ.dcen & modeQ.selB;
    din[2] = chainSync[2] & modeQ.dcen & modeQ.selC;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int L = laneLen(g, WORD_W);
    localparam int IW = $clog2(L);
    sershift_lane #(.LEN(L)) uLane (
      .clk    (clk),
      .rst    (rst),
      .load   (strb.load),
      .shift  (strb.shift),
      .loadVal(loadVal[g][L-1:0]),
      .din    (din[g]),
      .tap    (tap[g][IW-1:0]),
      .sdo    (sdo[g])
    );
  end

endmodule

// File: rtl/sershift_top.sv
module sershift_top
  import sershift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordA0,
  input  logic [WORD_W-1:0] wordA1,
  input  logic [WORD_W-1:0] wordB0,
  input  logic [WORD_W-1:0] wordB1,
  input  logic [WORD_W-1:0] wordC0,
  input  logic [WORD_W-1:0] wordC1,
  input  logic              serClk,
  input  logic              frameSync,
  input  logic              laneSelB,
  input  logic              laneSelC,
  input  logic              chainEn,
  input  logic              chainInA,
  input  logic              chainInB,
  input  logic              chainInC,
  output logic              sdoA,
  output logic              sdoB,
  output logic              sdoC
);

  strobe_t                          strb;
  mode_t                            modeIn, modeQ;
  logic [NUM_LANES-1:0]             chainSync, sdo;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  assign words  = {wordC1, wordC0, wordB1, wordB0, wordA1, wordA0};
  assign modeIn = '{selB: laneSelB, selC: laneSelC, dcen: chainEn};

  sershift_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .serClk   (serClk),
    .frameSync(frameSync),
    .chainIn  ({chainInC, chainInB, chainInA}),
    .strb     (strb),
    .chainSync(chainSync)
  );

  sershift_dp #(.WORD_W(WORD_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .modeIn   (modeIn),
    .words    (words),
    .chainSync(chainSync),
    .modeQ    (modeQ),
    .sdo      (sdo)
  );

  assign sdoA = sdo[0];
  assign sdoB = sdo[1];
  assign sdoC = sdo[2];

endmodule

// File: rtl/sershift_chk.sv
module sershift_chk
  import sershift_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input strobe_t strb,
  input mode_t   modeQ,
  input logic    sdoA,
  input logic    sdoB,
  input logic    sdoC
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ({sdoA, sdoB, sdoC} == 3'b000));

  // R9
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.shift) |=> $stable({sdoA, sdoB, sdoC}));

  // R8
  laneB_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !modeQ.selB |-> !sdoB);

  // R8
  laneC_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !modeQ.selC |-> !sdoC);

endmodule

bind sershift_top sershift_chk uChk (
  .clk  (clk),
  .rst  (rst),
  .strb (strb),
  .modeQ(modeQ),
  .sdoA (sdoA),
  .sdoB (sdoB),
  .sdoC (sdoC)
);

// File: tb/tb_sershift_top.sv
module tb_sershift_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] w [6];
  logic serClk = 1'b1, frameSync = 1'b1;
  logic laneSelB = 1'b1, laneSelC = 1'b1, chainEn = 1'b0;
  logic chainInA = 1'b0, chainInB = 1'b0, chainInC = 1'b0;
  logic sdoA, sdoB, sdoC;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0]  eW [6];
  logic         eSelB, eSelC, eDcen;
  logic [127:0] pat [3];
  logic [127:0] cap [3];

  always #10 clk = ~clk;

  sershift_top dut (
    .clk(clk), .rst(rst),
    .wordA0(w[0]), .wordA1(w[1]), .wordB0(w[2]), .wordB1(w[3]),
    .wordC0(w[4]), .wordC1(w[5]),
    .serClk(serClk), .frameSync(frameSync),
    .laneSelB(laneSelB), .laneSelC(laneSelC), .chainEn(chainEn),
    .chainInA(chainInA), .chainInB(chainInB), .chainInC(chainInC),
    .sdoA(sdoA), .sdoB(sdoB), .sdoC(sdoC)
  );

  // Word index carried at a position of a lane, -1 when none
  function automatic int laneWord(int lane, int idx, logic sb, logic sc);
    case (lane)
      0: begin
        if (sb && sc) return (idx < 2) ? idx : -1;
        if (sb) return (idx < 2) ? idx : ((idx == 2) ? 4 : -1);
        if (sc) return (idx < 4) ? idx : -1;
        return (idx < 6) ? idx : -1;
      end
      1: begin
        if (!sb) return -1;
        if (sc) return (idx < 2) ? 2 + idx : -1;
        return (idx < 2) ? 2 + idx : ((idx == 2) ? 5 : -1);
      end
      default: return (sc && idx < 2) ? 4 + idx : -1;
    endcase
  endfunction

  function automatic logic expBit(int lane, int k);
    int n = 0;
    bit active;
    active = (lane == 0) || (lane == 1 && eSelB) || (lane == 2 && eSelC);
    if (!active) return 1'b0;
    while (laneWord(lane, n, eSelB, eSelC) >= 0) n++;
    if (k < n * 16) return eW[laneWord(lane, k / 16, eSelB, eSelC)][15 - (k % 16)];
    return eDcen ? pat[lane][k - n * 16] : 1'b0;
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startFrame();
    for (int i = 0; i < 6; i++) eW[i] = w[i];
    eSelB = laneSelB; eSelC = laneSelC; eDcen = chainEn;
    @(negedge clk);
    frameSync = 1'b0;
    waitClk(8);
  endtask

  task automatic endFrame();
    @(negedge clk);
    frameSync = 1'b1;
    waitClk(8);
  endtask

  task automatic clockBits(int first, int nbits);
    for (int k = first; k < first + nbits; k++) begin
      @(negedge clk);
      cap[0][k] = sdoA; cap[1][k] = sdoB; cap[2][k] = sdoC;
      serClk = 1'b0;
      chainInA = pat[0][k]; chainInB = pat[1][k]; chainInC = pat[2][k];
      waitClk(8);
      serClk = 1'b1;
      waitClk(8);
    end
  endtask

  task automatic checkLanes(string req, int nbits);
    for (int l = 0; l < 3; l++) begin
      int bad = -1;
      logic a = 1'b0, e = 1'b0;
      checks++;
      for (int k = 0; k < nbits; k++) begin
        if (bad < 0 && cap[l][k] !== expBit(l, k)) begin
          bad = k; a = cap[l][k]; e = expBit(l, k);
        end
      end
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s lane %0d bit %0d: actual %b expected %b", req, l, bad, a, e);
      end
    end
  endtask

  task automatic setWords(logic [15:0] base);
    for (int i = 0; i < 6; i++) w[i] = base ^ (16'h1111 * i[15:0]) ^ {i[3:0], 12'h5A3};
  endtask

  task automatic runFrame(string req, logic sb, logic sc, logic dc, int nbits);
    @(negedge clk);
    laneSelB = sb; laneSelC = sc; chainEn = dc;
    startFrame();
    clockBits(0, nbits);
    checkLanes(req, nbits);
    endFrame();
  endtask

  task automatic testReset();
    checks++;
    if ({sdoA, sdoB, sdoC} !== 3'b000) begin
      fails++;
      $display("FAIL R1 outputs after reset: actual %b expected 000", {sdoA, sdoB, sdoC});
    end
  endtask

  task automatic testHold();
    logic [2:0] held;
    setWords(16'hC3A5);
    pat[0] = '0; pat[1] = '0; pat[2] = '0;
    @(negedge clk);
    laneSelB = 1'b1; laneSelC = 1'b1; chainEn = 1'b0;
    startFrame();
    clockBits(0, 5);
    checkLanes("R2", 5);
    endFrame();
    held = {sdoA, sdoB, sdoC};
    for (int i = 0; i < 6; i++) begin
      serClk = 1'b0; waitClk(8);
      serClk = 1'b1; waitClk(8);
      checks++;
      if ({sdoA, sdoB, sdoC} !== held) begin
        fails++;
        $display("FAIL R9 edge %0d while frame sync high: actual %b expected %b",
                 i, {sdoA, sdoB, sdoC}, held);
      end
    end
  endtask

  task automatic testMidChange();
    setWords(16'h7E19);
    pat[0] = {64{2'b10}}; pat[1] = {64{2'b01}}; pat[2] = {32{4'b1100}};
    @(negedge clk);
    laneSelB = 1'b1; laneSelC = 1'b1; chainEn = 1'b0;
    startFrame();
    clockBits(0, 3);
    laneSelB = 1'b0; laneSelC = 1'b0; chainEn = 1'b1;
    setWords(16'h0F0F);
    clockBits(3, 45);
    checkLanes("R10", 48);
    endFrame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    setWords(16'h0000);
    pat[0] = '0; pat[1] = '0; pat[2] = '0;
    waitClk(5);
    rst = 1'b0;
    waitClk(4);
    testReset();

    // R3 with R8 tail zeros and R2 bit order
    setWords(16'h8421);
    runFrame("R3", 1'b1, 1'b1, 1'b0, 48);
    // R4 folded pair C
    setWords(16'hF00D);
    runFrame("R4", 1'b1, 1'b0, 1'b0, 56);
    // R5 single lane
    setWords(16'h3C96);
    runFrame("R5", 1'b0, 1'b0, 1'b0, 104);
    // R6 lane C without lane B
    setWords(16'hA5A5);
    runFrame("R6", 1'b0, 1'b1, 1'b0, 72);
    // R7 daisy chain on three lanes
    setWords(16'h1234);
    pat[0] = {8{16'hB38E}}; pat[1] = {8{16'h4D71}}; pat[2] = {8{16'hE2C5}};
    runFrame("R7", 1'b1, 1'b1, 1'b1, 56);
    // R7 daisy chain on a folded lane
    setWords(16'h5555);
    runFrame("R7", 1'b1, 1'b0, 1'b1, 60);
    // R8 inactive lanes ignore toggling chain inputs
    setWords(16'h9ABC);
    pat[1] = {64{2'b10}}; pat[2] = {64{2'b11}};
    runFrame("R8", 1'b0, 1'b0, 1'b1, 108);

    testHold();
    testMidChange();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule